// File: doc/BRIEF.md
# Packet-Slot Transmit Controller

This block is the transmit side of one fabric port. A central hub keeps every packet in a fixed 64-byte slot of a shared byte memory and passes this port 10-bit slot handles over a valid/ready handshake. The controller stores the handles in a local queue. For the handle at the head of the queue, it asks the hub for bytes one offset at a time. Each request carries a memory address made of the handle placed above the 6-bit offset.

The hub grants a request when its round-robin pointer reaches this port. It returns the byte with a strobe one cycle after the grant. Returned bytes go into a two-entry buffer. From there, a shift register sends them MSB first on MISO toward an external SPI master. The SPI clock's falling edges arrive as single-cycle pulses that are already synchronized to the system clock.

When the request for offset 63 is granted, the hub takes the slot back and the controller moves on to its next handle. When no byte is waiting in the buffer, the port sends zero bytes, which the far end reads as idle.

Top module: `pkt_tx_ctrl`

## Requirements
- R1: After reset, `slot_in_ready` is 1, `fetch_req` is 0, `fetch_addr` is 0, MISO is 0, and both the handle queue and the byte buffer are empty. The shift register holds 0x2A, so its MSB is 0.
- R2: The handle queue holds 16 handles. `slot_in_ready` is 0 while it is full, and an offered handle is not taken in that state. Every accepted handle is streamed exactly once, in the order it was accepted.
- R3: `fetch_req` is 1 only when the handle queue is non-empty and a buffer entry is free. Once raised, `fetch_req` and `fetch_addr` stay unchanged until a cycle in which `fetch_grant` is 1.
- R4: For each handle, the offsets are requested in the order 0, 1, …, 63. After the grant of offset 63, the controller moves to the next handle and the offset returns to 0.
- R5: `fetch_addr[15:6]` is the head handle and `fetch_addr[5:0]` is the offset. The byte on `ret_byte` is captured when `ret_valid` is 1, one cycle after the grant. A fetch is issued only when the buffered bytes plus the bytes in flight number fewer than 2, so no buffered byte is ever overwritten.
- R6: MISO is the MSB of an 8-bit shift register. On each `sclk_fall` pulse with `cs_n` low, the register loads the buffer head if the bit counter is 0 and otherwise shifts left by one. The counter counts 0 to 7 and wraps, so each byte goes out MSB first over 8 pulses.
- R7: A load with an empty buffer loads 0x00, both before any packet and in a gap within a packet.
- R8: While `cs_n` is 1, the shift register and the bit counter are cleared on every cycle, so MISO is 0 from the next cycle on. Buffered bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_in | input | 10 | Slot handle offered by the hub |
| slot_in_valid | input | 1 | A handle is offered |
| slot_in_ready | output | 1 | The handle queue has room |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | 16 | Handle above offset |
| fetch_grant | input | 1 | The hub accepts the request this cycle |
| ret_byte | input | 8 | Returned memory byte |
| ret_valid | input | 1 | `ret_byte` is valid, one cycle after a grant |
| cs_n | input | 1 | SPI chip select, active low |
| sclk_fall | input | 1 | Synchronized SCLK falling-edge pulse |
| miso | output | 1 | Serial data out |

## Verification
The bench starts with an idle stream and no handles, which shows the zero fill on loads with an empty buffer. It then streams a single packet and raises chip select after three bits. This separates the clear behaviour from normal shifting and shows that the buffered bytes that follow are not lost. Next, 16 handles are queued while the hub grants nothing. This probes the full-queue refusal and the request hold, and the drain that follows tests ordering and offset wrap across many slots. A last run uses a hub slower than the SPI side, which forces idle bytes in the middle of a packet without losing any data.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SHIFT_RST_VAL = 8'h2A;
    localparam logic [BYTE_W-1:0] IDLE_VAL = 8'h00;
    localparam int BITCNT_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t               shreg;
        logic [BITCNT_W-1:0] bitcnt;
    } shifter_st_t;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push, pop;

    always_comb begin
        st_d     = st_q;
        wr_ready = (st_q.cnt != (AW+1)'(DEPTH));
        empty    = (st_q.cnt == '0);
        push     = wr_valid && wr_ready;
        pop      = rd_en && !empty;
        if (push) begin
            st_d.mem[st_q.wr] = wr_data;
            st_d.wr           = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        if (push && !pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        rd_data = st_q.mem[st_q.rd];
        level   = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tx_fetch_seq.sv
module tx_fetch_seq #(
    parameter int SLOT_W    = 10,
    parameter int OFS_W     = 6,
    parameter int BUF_DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          have_slot,
    input  logic [SLOT_W-1:0]             head_slot,
    input  logic [$clog2(BUF_DEPTH):0]    buf_level,
    input  logic                          fetch_grant,
    input  logic                          ret_valid,
    output logic                          fetch_req,
    output logic [SLOT_W+OFS_W-1:0]       fetch_addr,
    output logic                          slot_done
);
    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             pend;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic take;
    int   occ;

    always_comb begin
        st_d       = st_q;
        occ        = int'(buf_level) + int'(st_q.pend);
        fetch_req  = have_slot && (occ < BUF_DEPTH);
        fetch_addr = {head_slot, st_q.ofs};
        take       = fetch_req && fetch_grant;
        slot_done  = take && (&st_q.ofs);
        st_d.pend  = take || (st_q.pend && !ret_valid);
        if (take) begin
            st_d.ofs = st_q.ofs + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tx_miso_shifter.sv
module tx_miso_shifter
    import pkt_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_n,
    input  logic  sclk_fall,
    input  logic  buf_empty,
    input  byte_t buf_head,
    output logic  buf_pop,
    output logic  miso
);
    shifter_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        buf_pop = 1'b0;
        if (cs_n) begin
            st_d.shreg  = '0;
            st_d.bitcnt = '0;
        end else if (sclk_fall) begin
            if (st_q.bitcnt == '0) begin
                st_d.shreg = buf_empty ? IDLE_VAL : buf_head;
                buf_pop    = !buf_empty;
            end else begin
                st_d.shreg = {st_q.shreg[BYTE_W-2:0], 1'b0};
            end
            st_d.bitcnt = st_q.bitcnt + 1'b1;
        end
        miso = st_q.shreg[BYTE_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shreg  <= SHIFT_RST_VAL;
            st_q.bitcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl
    import pkt_tx_pkg::*;
#(
    parameter int SLOT_W    = 10,
    parameter int OFS_W     = 6,
    parameter int HQ_DEPTH  = 16,
    parameter int BUF_DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SLOT_W-1:0]       slot_in,
    input  logic                    slot_in_valid,
    output logic                    slot_in_ready,
    output logic                    fetch_req,
    output logic [SLOT_W+OFS_W-1:0] fetch_addr,
    input  logic                    fetch_grant,
    input  logic [BYTE_W-1:0]       ret_byte,
    input  logic                    ret_valid,
    input  logic                    cs_n,
    input  logic                    sclk_fall,
    output logic                    miso
);
    localparam int HQ_AW  = $clog2(HQ_DEPTH);
    localparam int BUF_AW = $clog2(BUF_DEPTH);

    logic [SLOT_W-1:0] head_slot;
    logic              hq_empty;
    logic [HQ_AW:0]    hq_cnt;
    logic              slot_done;

    logic              bq_wr_ready;
    byte_t             bq_head;
    logic              bq_empty;
    logic [BUF_AW:0]   bq_cnt;
    logic              bq_pop;

    tx_fifo #(.W(SLOT_W), .DEPTH(HQ_DEPTH)) i_slot_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (slot_in_valid),
        .wr_ready (slot_in_ready),
        .wr_data  (slot_in),
        .rd_en    (slot_done),
        .rd_data  (head_slot),
        .empty    (hq_empty),
        .level    (hq_cnt)
    );

    tx_fetch_seq #(.SLOT_W(SLOT_W), .OFS_W(OFS_W), .BUF_DEPTH(BUF_DEPTH)) i_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .have_slot   (!hq_empty),
        .head_slot   (head_slot),
        .buf_level   (bq_cnt),
        .fetch_grant (fetch_grant),
        .ret_valid   (ret_valid),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .slot_done   (slot_done)
    );

    tx_fifo #(.W(BYTE_W), .DEPTH(BUF_DEPTH)) i_byte_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (ret_valid),
        .wr_ready (bq_wr_ready),
        .wr_data  (ret_byte),
        .rd_en    (bq_pop),
        .rd_data  (bq_head),
        .empty    (bq_empty),
        .level    (bq_cnt)
    );

    tx_miso_shifter i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_fall (sclk_fall),
        .buf_empty (bq_empty),
        .buf_head  (bq_head),
        .buf_pop   (bq_pop),
        .miso      (miso)
    );
endmodule

module pkt_tx_ctrl_chk #(
    parameter int SLOT_W    = 10,
    parameter int OFS_W     = 6,
    parameter int HQ_DEPTH  = 16,
    parameter int BUF_DEPTH = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        slot_in_valid,
    input logic                        slot_in_ready,
    input logic                        fetch_req,
    input logic [SLOT_W+OFS_W-1:0]     fetch_addr,
    input logic                        fetch_grant,
    input logic                        ret_valid,
    input logic                        cs_n,
    input logic                        miso,
    input logic [$clog2(HQ_DEPTH):0]   hq_cnt,
    input logic [$clog2(BUF_DEPTH):0]  bq_cnt,
    input logic                        bq_wr_ready
);
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_grant |=> fetch_req && $stable(fetch_addr));

    assert_req_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (hq_cnt != '0) && (int'(bq_cnt) < BUF_DEPTH));

    assert_ofs_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_grant && (&fetch_addr[OFS_W-1:0]) |=> fetch_addr[OFS_W-1:0] == '0);

    assert_ofs_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_grant && !(&fetch_addr[OFS_W-1:0])
        |=> fetch_addr[OFS_W-1:0] == $past(fetch_addr[OFS_W-1:0]) + 1'b1);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> bq_wr_ready);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_in_valid && slot_in_ready |=> hq_cnt != '0);

    assert_cs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso);
endmodule

bind pkt_tx_ctrl pkt_tx_ctrl_chk #(
    .SLOT_W(SLOT_W), .OFS_W(OFS_W), .HQ_DEPTH(HQ_DEPTH), .BUF_DEPTH(BUF_DEPTH)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_in_valid (slot_in_valid),
    .slot_in_ready (slot_in_ready),
    .fetch_req     (fetch_req),
    .fetch_addr    (fetch_addr),
    .fetch_grant   (fetch_grant),
    .ret_valid     (ret_valid),
    .cs_n          (cs_n),
    .miso          (miso),
    .hq_cnt        (hq_cnt),
    .bq_cnt        (bq_cnt),
    .bq_wr_ready   (bq_wr_ready)
);

// File: tb/test_pkt_tx_ctrl.sv
module test_pkt_tx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  slot_in = '0;
    logic        slot_in_valid = 1'b0;
    logic        slot_in_ready;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic        fetch_grant = 1'b0;
    logic [7:0]  ret_byte = '0;
    logic        ret_valid = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk_fall = 1'b0;
    logic        miso;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_q[$];
    logic [9:0] hub_q[$];
    logic [5:0] hub_ofs = '0;
    bit         hub_on = 1'b0;
    int         hub_period = 4;
    int         rr = 0;
    bit         pend_ret = 1'b0;
    logic [15:0] pend_addr = '0;

    always #2 clk = ~clk;

    pkt_tx_ctrl i_pkt_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_in(slot_in), .slot_in_valid(slot_in_valid),
        .slot_in_ready(slot_in_ready), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_grant(fetch_grant), .ret_byte(ret_byte), .ret_valid(ret_valid),
        .cs_n(cs_n), .sclk_fall(sclk_fall), .miso(miso)
    );

    function automatic logic [7:0] mem_of(input logic [15:0] a);
        return {1'b1, a[5:0] ^ a[11:6], a[12]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // hub model: grant on its round-robin turn, return the byte one cycle later
    always @(negedge clk) begin
        if (pend_ret) begin
            ret_valid = 1'b1;
            ret_byte  = mem_of(pend_addr);
        end else begin
            ret_valid = 1'b0;
        end
        rr = (rr + 1) % hub_period;
        fetch_grant = rst_n && hub_on && fetch_req && (rr == 0);
        pend_ret = fetch_grant;
        if (fetch_grant) begin
            pend_addr = fetch_addr;
            if (hub_q.size() == 0) begin
                check(1'b0, "R3 request without queued handle", fetch_addr, 0);
            end else begin
                check(fetch_addr == {hub_q[0], hub_ofs}, "R4/R5 fetch address",
                      fetch_addr, {hub_q[0], hub_ofs});
                hub_ofs = hub_ofs + 1'b1;
                if (hub_ofs == 6'd0) void'(hub_q.pop_front());
            end
        end
    end

    // driver: offer one handle, record expected bytes when accepted
    task automatic try_push(input logic [9:0] s, output bit ok);
        @(negedge clk);
        ok = slot_in_ready;
        if (ok) begin
            slot_in = s;
            slot_in_valid = 1'b1;
            @(negedge clk);
            slot_in_valid = 1'b0;
            hub_q.push_back(s);
            for (int o = 0; o < 64; o++) exp_q.push_back(mem_of({s, 6'(o)}));
        end
    endtask

    task automatic spi_bit(output logic b);
        @(negedge clk); sclk_fall = 1'b1;
        @(negedge clk); sclk_fall = 1'b0;
        b = miso;
        repeat (2) @(negedge clk);
    endtask

    task automatic spi_byte(output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            spi_bit(b);
            v = {v[6:0], b};
        end
    endtask

    // monitor: pop and compare each non-idle byte leaving on MISO
    task automatic drain(input int limit, output int idles);
        logic [7:0] v;
        int n = 0;
        idles = 0;
        while (exp_q.size() != 0 && n < limit) begin
            spi_byte(v);
            n++;
            if (v == 8'h00) idles++;
            else begin
                logic [7:0] e = exp_q.pop_front();
                check(v == e, "R2/R6 streamed byte", v, e);
            end
        end
        check(exp_q.size() == 0, "R2 all accepted handles streamed", exp_q.size(), 0);
    endtask

    task automatic run();
        bit ok;
        logic b;
        logic [7:0] v;
        int idles;
        logic [7:0] first;
        logic [15:0] held;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(slot_in_ready == 1'b1, "R1 ready after reset", slot_in_ready, 1);
        check(fetch_req == 1'b0, "R1 no request after reset", fetch_req, 0);
        check(fetch_addr == 16'h0, "R1 offset zero after reset", fetch_addr, 0);
        check(miso == 1'b0, "R1 MISO is MSB of 0x2A", miso, 0);

        hub_on = 1'b1;
        cs_n = 1'b0;
        spi_byte(v);
        check(v == 8'h00, "R7 idle byte before any packet", v, 0);
        spi_byte(v);
        check(v == 8'h00, "R7 second idle byte", v, 0);

        // R8: abort a byte with chip select
        try_push(10'h155, ok);
        check(ok, "R2 handle accepted", ok, 1);
        repeat (40) @(negedge clk);
        first = exp_q[0];
        for (int i = 0; i < 3; i++) begin
            spi_bit(b);
            check(b == first[7-i], "R6 MSB-first bit", b, first[7-i]);
        end
        cs_n = 1'b1;
        @(negedge clk);
        check(miso == 1'b0, "R8 MISO cleared by chip select", miso, 0);
        spi_bit(b);
        check(b == 1'b0, "R8 pulses ignored while deselected", b, 0);
        void'(exp_q.pop_front());
        cs_n = 1'b0;
        drain(200, idles);
        spi_byte(v);
        check(v == 8'h00, "R7 idle after packet end", v, 0);

        // R2/R3: fill the handle queue while the hub grants nothing
        hub_on = 1'b0;
        for (int i = 0; i < 16; i++) begin
            try_push(10'((i * 37 + 3) % 1024), ok);
            check(ok, "R2 handle accepted below depth", ok, 1);
        end
        @(negedge clk);
        check(slot_in_ready == 1'b0, "R2 ready low when full", slot_in_ready, 0);
        try_push(10'h3FF, ok);
        check(!ok, "R2 17th handle refused", ok, 0);
        check(fetch_req == 1'b1, "R3 request raised", fetch_req, 1);
        held = fetch_addr;
        repeat (20) @(negedge clk);
        check(fetch_req == 1'b1 && fetch_addr == held, "R3 request held without grant",
              fetch_addr, held);
        check(held == {10'd3, 6'd0}, "R5 address is handle above offset", held, {10'd3, 6'd0});
        hub_on = 1'b1;
        drain(1100, idles);
        spi_byte(v);
        check(v == 8'h00, "R7 idle after queue drained", v, 0);

        // R7: slow hub forces idle bytes inside a packet
        hub_period = 48;
        try_push(10'h2C1, ok);
        try_push(10'h00F, ok);
        drain(400, idles);
        check(idles > 0, "R7 idle bytes inserted mid-packet", idles, 1);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (190000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule